// File: doc/BRIEF.md
# Two-Line Level Interrupt Router

This block gathers a word of level-sensitive interrupt inputs, masks each one with its own enable bit, and sends every enabled source to one of two processor interrupt lines according to a per-source routing bit. Each source input is resynchronised to the block clock before it is used. A source stays pending for as long as its input is held high. Software clears the pending state at the source, not here.

Enables are never written as a whole word. One register sets the enable bits whose data bits are 1, and another register clears them. Bit 31 of the enable word has a second role as a master gate: while it is 0, neither line can assert. Software reads the synchronised input levels and two masked views, one per output line. A small helper also reports the lowest-numbered pending source on line 0, so that a handler can service sources in order of index.

The register bus is a single-cycle interface with byte address, write strobe, write data and combinational read data. Writes take effect at the clock edge on which the strobe is sampled.

Top module: `dual_line_irq_ctrl`

## Requirements
- R1: After reset the enable word and the routing word are both 0, so both lines are low and every masked view reads 0.
- R2: The raw view at offset 0x30 returns the input levels two clock edges after they are applied, and it is not masked by enables or routing.
- R3: A write to offset 0x34 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Reads of 0x34 and of 0x38 both return the enable word.
- R4: A write to offset 0x38 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Writing all ones clears the whole word.
- R5: While enable bit 31 (the master gate) is 0, both masked views read 0 and both lines stay low, whatever the inputs and the other enables are.
- R6: The routing word at offset 0x20 is written and read as a whole. The view for line 0 at offset 0x00 equals raw AND enable AND NOT routing, and the view for line 1 at offset 0x04 equals raw AND enable AND routing, both gated by the master bit. A routing bit of 0 selects line 0.
- R7: Each line is high exactly when its own masked view is nonzero.
- R8: Writes to offsets 0x00, 0x04 and 0x30 change no state. Reads from any offset other than 0x00, 0x04, 0x20, 0x30, 0x34 and 0x38 return 0.
- R9: The helper outputs the index of the lowest set bit of the line-0 view, with a valid flag that is high exactly when that view is nonzero.
- R10: A source stays pending for as long as its input is held high, and its pending state ends two clock edges after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | 32 | Asynchronous level interrupt inputs, one bit per source |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_line0 | output | 1 | Interrupt request line 0 |
| irq_line1 | output | 1 | Interrupt request line 1 |
| low_idx | output | 5 | Index of the lowest pending source on line 0 |
| low_valid | output | 1 | High when low_idx is meaningful |

## Verification
The bench builds the block with its default parameters: 32 sources, a two-stage synchroniser and an 8-bit address. At that size, walking a single bit across every position is cheap. The bench therefore sweeps every source through the raw view, every routing bit through both masked views, and every lowest-index position through the helper. With the two-stage depth, the latency of the synchroniser can be checked edge by edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam logic [7:0] OFF_VIEW0 = 8'h00;
    localparam logic [7:0] OFF_VIEW1 = 8'h04;
    localparam logic [7:0] OFF_ROUTE = 8'h20;
    localparam logic [7:0] OFF_RAW   = 8'h30;
    localparam logic [7:0] OFF_ENSET = 8'h34;
    localparam logic [7:0] OFF_ENCLR = 8'h38;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] route_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] route;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFF_ENSET)) ctl_d.en    = ctl_q.en | wr_data;
            if (wr_addr == ADDR_W'(OFF_ENCLR)) ctl_d.en    = ctl_q.en & ~wr_data;
            if (wr_addr == ADDR_W'(OFF_ROUTE)) ctl_d.route = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_q    = ctl_q.en;
    assign route_q = ctl_q.route;
endmodule

// File: rtl/irq_route_mask.sv
module irq_route_mask #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] route,
    output logic [NUM_SRC-1:0] view0,
    output logic [NUM_SRC-1:0] view1,
    output logic               line0,
    output logic               line1
);
    localparam int GATE_BIT = NUM_SRC - 1;

    logic [NUM_SRC-1:0] live;

    always_comb begin
        live  = (raw & en) & {NUM_SRC{en[GATE_BIT]}};
        view0 = live & ~route;
        view1 = live & route;
        line0 = |view0;
        line1 = |view1;
    end
endmodule

// File: rtl/irq_low_index.sv
module irq_low_index #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic [IDX_W-1:0]   idx,
    output logic               valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dual_line_irq_ctrl.sv
module dual_line_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_level,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [NUM_SRC-1:0]         bus_wdata,
    output logic [NUM_SRC-1:0]         bus_rdata,
    output logic                       irq_line0,
    output logic                       irq_line1,
    output logic [$clog2(NUM_SRC)-1:0] low_idx,
    output logic                       low_valid
);
    logic [NUM_SRC-1:0] raw_q, en_q, type_q, view0, view1;

    irq_level_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src_level), .sync_out(raw_q)
    );

    irq_ctl_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .en_q(en_q), .route_q(type_q)
    );

    irq_route_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .raw(raw_q), .en(en_q), .route(type_q),
        .view0(view0), .view1(view1), .line0(irq_line0), .line1(irq_line1)
    );

    irq_low_index #(.NUM_SRC(NUM_SRC)) u_low (
        .pend(view0), .idx(low_idx), .valid(low_valid)
    );

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFF_VIEW0)) bus_rdata = view0;
        else if (bus_addr == ADDR_W'(OFF_VIEW1)) bus_rdata = view1;
        else if (bus_addr == ADDR_W'(OFF_ROUTE)) bus_rdata = type_q;
        else if (bus_addr == ADDR_W'(OFF_RAW))   bus_rdata = raw_q;
        else if (bus_addr == ADDR_W'(OFF_ENSET) ||
                 bus_addr == ADDR_W'(OFF_ENCLR)) bus_rdata = en_q;
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] en_mask,
    input logic [NUM_SRC-1:0] type_mask,
    input logic               irq_line0,
    input logic               irq_line1,
    input logic               low_valid
);
    localparam int GATE_BIT = NUM_SRC - 1;

    logic wr_set, wr_clr, wr_ro;
    assign wr_set = bus_we && (bus_addr == ADDR_W'(OFF_ENSET));
    assign wr_clr = bus_we && (bus_addr == ADDR_W'(OFF_ENCLR));
    assign wr_ro  = bus_we && (bus_addr == ADDR_W'(OFF_VIEW0) ||
                               bus_addr == ADDR_W'(OFF_VIEW1) ||
                               bus_addr == ADDR_W'(OFF_RAW));

    a_r3_set_bits_land: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_mask & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_clear_bits_land: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_mask & $past(bus_wdata)) == '0));

    a_r5_gate_blocks_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[GATE_BIT] |-> (!irq_line0 && !irq_line1));

    a_r8_ro_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro |=> ($stable(en_mask) && $stable(type_mask)));

    a_r9_valid_tracks_line0: assert property (@(posedge clk) disable iff (!rst_n)
        low_valid == irq_line0);
endmodule

bind dual_line_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_mask(en_q), .type_mask(type_q),
    .irq_line0(irq_line0), .irq_line1(irq_line1), .low_valid(low_valid)
);

// File: tb/tb_dual_line_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_line_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_level = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_line0, irq_line1, low_valid;
    logic [4:0]  low_idx;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dual_line_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line0(irq_line0), .irq_line1(irq_line1),
        .low_idx(low_idx), .low_valid(low_valid)
    );

    logic [31:0] m_en = '0, m_type = '0, m_src = '0;

    function automatic logic [31:0] exp_view(input bit sel);
        logic [31:0] live = m_src & m_en & {32{m_en[31]}};
        return sel ? (live & m_type) : (live & ~m_type);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(negedge clk);
        src_level = v; m_src = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_views(input string tag);
        logic [31:0] v;
        rd(8'h00, v); chk({tag, " view0"}, v, exp_view(1'b0));
        rd(8'h04, v); chk({tag, " view1"}, v, exp_view(1'b1));
        chk({tag, " line0"}, {31'b0, irq_line0}, {31'b0, |exp_view(1'b0)});
        chk({tag, " line1"}, {31'b0, irq_line1}, {31'b0, |exp_view(1'b1)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h34, v); chk("R1 enable", v, 32'h0);
        rd(8'h20, v); chk("R1 route", v, 32'h0);
        check_views("R1");

        // R2 raw latency: old value after one edge, new after two
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            bus_addr = 8'h30;
            src_level = 32'h1 << i; m_src = src_level;
            @(negedge clk); #1 chk("R2 raw one edge", bus_rdata, (i == 0) ? 32'h0 : (32'h1 << (i - 1)));
            @(negedge clk); #1 chk("R2 raw two edges", bus_rdata, 32'h1 << i);
        end

        // R3 set register
        wr(8'h34, 32'h0000_00F0); m_en |= 32'h0000_00F0;
        rd(8'h34, v); chk("R3 set a", v, m_en);
        wr(8'h34, 32'h0000_0000);
        rd(8'h34, v); chk("R3 zero write keeps", v, m_en);
        wr(8'h34, 32'h0F00_0003); m_en |= 32'h0F00_0003;
        rd(8'h34, v); chk("R3 set b", v, m_en);
        rd(8'h38, v); chk("R3 read via clear offset", v, m_en);

        // R4 clear register
        wr(8'h38, 32'h0000_0030); m_en &= ~32'h0000_0030;
        rd(8'h34, v); chk("R4 clear part", v, m_en);
        wr(8'h38, 32'hFFFF_FFFF); m_en = '0;
        rd(8'h34, v); chk("R4 clear all", v, 32'h0);

        // R5 gate off with every other enable on
        drive_src(32'hFFFF_FFFF);
        wr(8'h34, 32'h7FFF_FFFF); m_en = 32'h7FFF_FFFF;
        wr(8'h20, 32'h5555_5555); m_type = 32'h5555_5555;
        check_views("R5 gate off");
        wr(8'h34, 32'h8000_0000); m_en = 32'hFFFF_FFFF;
        check_views("R5 gate on");

        // R6 and R7 routing sweep
        for (int i = 0; i < 32; i++) begin
            wr(8'h20, 32'h1 << i); m_type = 32'h1 << i;
            rd(8'h20, v); chk("R6 route readback", v, m_type);
            check_views("R6 R7 route sweep");
        end
        wr(8'h20, 32'hFFFF_FFFF); m_type = 32'hFFFF_FFFF;
        drive_src(32'h0000_0100);
        check_views("R7 only line1");
        wr(8'h20, 32'h0); m_type = '0;
        check_views("R6 all to line0");

        // R9 lowest index sweep
        for (int i = 0; i < 32; i++) begin
            drive_src(32'hFFFF_FFFF << i);
            chk("R9 low idx", {27'b0, low_idx}, i);
            chk("R9 low valid", {31'b0, low_valid}, 32'h1);
        end
        drive_src(32'h0);
        chk("R9 none valid", {31'b0, low_valid}, 32'h0);

        // R8 read-only writes and unmapped reads
        wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h30, 32'h0);
        rd(8'h34, v); chk("R8 enable unchanged", v, m_en);
        rd(8'h20, v); chk("R8 route unchanged", v, m_type);
        rd(8'h10, v); chk("R8 unmapped 0x10", v, 32'h0);
        rd(8'h24, v); chk("R8 unmapped 0x24", v, 32'h0);
        rd(8'h3C, v); chk("R8 unmapped 0x3C", v, 32'h0);
        rd(8'hFC, v); chk("R8 unmapped 0xFC", v, 32'h0);

        // R10 level hold and release timing
        drive_src(32'h0000_0004);
        repeat (10) @(negedge clk);
        chk("R10 held pending", {31'b0, irq_line0}, 32'h1);
        src_level = 32'h0;
        @(negedge clk); #1 chk("R10 one edge after fall", {31'b0, irq_line0}, 32'h1);
        @(negedge clk); #1 chk("R10 two edges after fall", {31'b0, irq_line0}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule